// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block is the interrupt register file of a four-processor system. Device interrupt lines come in as one 32-bit level-sensitive vector. They are filtered by a master mask word and turned into priority levels through a fixed table. They are then steered to the one processor named by a target register. Each processor also owns a pending word that software fills with hardware-level and software-level requests. Each processor receives a 4-bit level: 0 means idle, and 1 to 15 is the highest request that currently applies to it.

Software uses a plain word-addressed register bus. The set and clear registers act only on the bits written as 1. The mask sense is inverted: a clear write enables a source and a set write disables it. A read returns its data one cycle after the request.

Top module: `mp_irq_mask_ctrl`

## Requirements
- R1: Each processor's 4-bit level output is the highest requested level that applies to it, and 0 when nothing applies. A change reaches the output after one rising clock edge, whether it comes from a register write or from a device input.
- R2: For processor c, word address 4c reads its pending word, 4c+1 clears pending bits and 4c+2 sets pending bits. In both writes only the data bits at 1 act, and bits at 0 leave the word unchanged.
- R3: In a pending word, a hardware request at level x is bit x and a software request at level x is bit 16+x. Bits 0 and 16 cannot be set and always read 0.
- R4: The master mask reads at address 17 and resets to all ones. A 1 written at address 18 clears that mask bit and enables the source. A 1 written at address 19 sets that mask bit and disables the source.
- R5: While mask bit 31 is 1, no device source reaches any processor, whatever the other mask bits hold.
- R6: Device bits map to levels as follows: bits 28, 29 and 30 to 15; bit 21 to 14; bit 17 to 13; bits 15 and 14 to 12; bit 22 to 11; bit 19 to 10; bit 20 to 8; bit 16 to 6; bit 18 to 4; bits 7 to 12 to levels 1 to 6 in order. All other bits map to level 0 and have no effect.
- R7: Unmasked device sources affect only the processor selected by the target register.
- R8: After reset, all pending words are 0, the mask is all ones, the target is processor 0 and every level output is 0.
- R9: The device status word at address 16 is the input vector as sampled on the previous edge. It is not latched, so a mask write cannot drop a request whose input is still high.
- R10: The target register at address 20 is read/write. A written value is reduced modulo the processor count, so writing 7 selects processor 3.
- R11: A read request returns data on the cycle after it is made, with the valid flag high on that cycle only. Write-only and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| dev_irq | input | 32 | Level-sensitive device requests |
| cpu_level | output | 16 | Per-processor level, processor c at bits 4c+3:4c |

## Verification
The hardest case to reach is a device request passing to a processor. It needs the source input high, its own mask bit cleared, the global mask bit 31 cleared, and the target pointing at that processor, all at once. Random mask writes alone seldom bring all of these together, because the mask resets to all ones. The stimulus therefore biases mask-clear writes toward bit 31 and runs directed sequences that unmask a source one condition at a time. It then moves the target and checks that the request moves with it. It also checks that a clear write on an asserted input does not drop that request.

// File: rtl/mp_irq_mask_ctrl.sv
module mp_irq_mask_ctrl #(
  parameter int NCPU = 4,
  parameter int AW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic [31:0]      dev_irq,
  output logic [NCPU*4-1:0] cpu_level
);

  localparam int TW    = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int MBASE = 4 * NCPU;
  localparam logic [31:0] PEND_OK = 32'hFFFE_FFFE;
  localparam logic [AW-1:0] A_STAT = AW'(MBASE);
  localparam logic [AW-1:0] A_MASK = AW'(MBASE + 1);
  localparam logic [AW-1:0] A_MCLR = AW'(MBASE + 2);
  localparam logic [AW-1:0] A_MSET = AW'(MBASE + 3);
  localparam logic [AW-1:0] A_TGT  = AW'(MBASE + 4);

  logic [31:0] pend_q [NCPU];
  logic [31:0] mask_q, dev_q, dev_eff, rd_mux;
  logic [TW-1:0] tgt_q;
  logic [15:0] dev_vec;

  function automatic logic [3:0] src_level(input int b);
    case (b)
      28, 29, 30: return 4'd15;
      21:         return 4'd14;
      17:         return 4'd13;
      14, 15:     return 4'd12;
      22:         return 4'd11;
      19:         return 4'd10;
      20:         return 4'd8;
      16:         return 4'd6;
      18:         return 4'd4;
      7, 8, 9, 10, 11, 12: return 4'(b - 6);
      default:    return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] top_level(input logic [15:0] v);
    logic [3:0] r;
    r = '0;
    for (int l = 1; l < 16; l++)
      if (v[l]) r = 4'(l);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCPU; c++) pend_q[c] <= '0;
      mask_q <= '1;
      dev_q  <= '0;
      tgt_q  <= '0;
    end else begin
      dev_q <= dev_irq;
      if (bus_we) begin
        for (int c = 0; c < NCPU; c++) begin
          if (bus_addr == AW'(4*c + 1)) pend_q[c] <= pend_q[c] & ~(bus_wdata & PEND_OK);
          if (bus_addr == AW'(4*c + 2)) pend_q[c] <= pend_q[c] | (bus_wdata & PEND_OK);
        end
        if (bus_addr == A_MCLR) mask_q <= mask_q & ~bus_wdata;
        if (bus_addr == A_MSET) mask_q <= mask_q | bus_wdata;
        if (bus_addr == A_TGT)  tgt_q  <= TW'(bus_wdata % 32'(NCPU));
      end
    end
  end

  assign dev_eff = mask_q[31] ? 32'h0 : (dev_q & ~mask_q);

  always_comb begin
    dev_vec = '0;
    for (int b = 0; b < 32; b++)
      if (dev_eff[b]) dev_vec[src_level(b)] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCPU; c++)
      if (bus_addr == AW'(4*c)) rd_mux = pend_q[c];
    if (bus_addr == A_STAT) rd_mux = dev_q;
    if (bus_addr == A_MASK) rd_mux = mask_q;
    if (bus_addr == A_TGT)  rd_mux = 32'(tgt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      bus_rdata  <= bus_re ? rd_mux : 32'h0;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_level[4*c +: 4] = top_level(pend_q[c][15:0] | pend_q[c][31:16] |
                                           ((tgt_q == TW'(c)) ? dev_vec : 16'h0));

    assert_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(4*c + 1) && bus_wdata == 32'hFFFF_FFFF) |=> pend_q[c] == 32'h0);

    assert_global_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[31] && pend_q[c] == 32'h0) |-> cpu_level[4*c +: 4] == 4'd0);

    assert_only_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q != TW'(c) && pend_q[c] == 32'h0) |-> cpu_level[4*c +: 4] == 4'd0);
  end

  assert_read_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);

  assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (bus_addr == A_MCLR || bus_addr == A_MSET)) |=> bus_rdata == 32'h0);

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MSET) |=> (mask_q & $past(bus_wdata)) == $past(bus_wdata));

endmodule

// File: tb/mp_irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module mp_irq_mask_ctrl_test;
  localparam int NCPU = 4;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [31:0] dev_irq = '0;
  logic [NCPU*4-1:0] cpu_level;

  always #4 clk = ~clk;

  mp_irq_mask_ctrl #(.NCPU(NCPU), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dev_irq(dev_irq), .cpu_level(cpu_level));

  int total = 0, bad = 0;
  logic [31:0] m_pend [NCPU];
  logic [31:0] m_mask, m_dev;
  int m_tgt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lvl_of(input int b);
    if (b >= 28 && b <= 30) return 15;
    if (b >= 7 && b <= 12) return b - 6;
    case (b)
      21: return 14; 17: return 13; 14: return 12; 15: return 12;
      22: return 11; 19: return 10; 20: return 8; 16: return 6; 18: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_level(input int c);
    logic [31:0] r;
    r = 0;
    for (int x = 1; x < 16; x++) begin
      if (m_pend[c][x] || m_pend[c][16+x]) r = x;
      if (c == m_tgt && !m_mask[31])
        for (int b = 0; b < 32; b++)
          if (m_dev[b] && !m_mask[b] && lvl_of(b) == x) r = x;
    end
    return r;
  endfunction

  function automatic logic [31:0] model_read(input int a);
    if (a < 4*NCPU && a % 4 == 0) return m_pend[a/4];
    if (a == 16) return m_dev;
    if (a == 17) return m_mask;
    if (a == 20) return 32'(m_tgt);
    return 32'h0;
  endfunction

  task automatic chk_levels(input string req);
    for (int c = 0; c < NCPU; c++)
      chk(req, 32'(cpu_level[4*c +: 4]), exp_level(c));
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    if (a < 4*NCPU && a % 4 == 1) m_pend[a/4] = m_pend[a/4] & ~(d & 32'hFFFE_FFFE);
    if (a < 4*NCPU && a % 4 == 2) m_pend[a/4] = m_pend[a/4] | (d & 32'hFFFE_FFFE);
    if (a == 18) m_mask = m_mask & ~d;
    if (a == 19) m_mask = m_mask | d;
    if (a == 20) m_tgt = int'(d % NCPU);
  endtask

  task automatic rd(input int a, input string req);
    logic [31:0] e;
    e = model_read(a);
    bus_addr = AW'(a); bus_re = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    chk({req, " rvalid"}, 32'(bus_rvalid), 32'h1);
    chk(req, bus_rdata, e);
  endtask

  task automatic set_dev(input logic [31:0] d);
    dev_irq = d;
    @(posedge clk); @(negedge clk);
    m_dev = d;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCPU; c++) m_pend[c] = 0;
    m_mask = 32'hFFFF_FFFF; m_dev = 0; m_tgt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk_levels("R8 reset levels");
    chk("R11 idle rvalid", 32'(bus_rvalid), 32'h0);
    rd(17, "R8 reset mask");
    rd(20, "R8 reset target");
    rd(4, "R8 reset pend");

    wr(6, 32'h0000_0020); chk_levels("R3 hard bit 5");
    wr(6, 32'h0200_0000); chk_levels("R3 soft bit 25 level 9");
    wr(6, 32'h0001_0001); rd(4, "R3 bits 0 and 16 stay zero");
    wr(5, 32'h0);         rd(4, "R2 zero clear no effect");
    wr(5, 32'h0200_0000); chk_levels("R2 clear soft back to 5");
    rd(5, "R11 write-only reads zero");
    rd(25, "R11 unmapped reads zero");

    set_dev(32'h0008_0000);
    wr(18, 32'h0008_0000); chk_levels("R5 global mask blocks timer");
    wr(18, 32'h8000_0000); chk_levels("R6 timer level 10 on cpu0");
    wr(20, 32'd2);        chk_levels("R7 timer moves to cpu2");
    wr(20, 32'd7);        rd(20, "R10 target modulo");
    chk_levels("R7 timer on cpu3");
    wr(19, 32'h0008_0000); chk_levels("R4 set masks timer");
    rd(17, "R4 mask readback");

    set_dev(32'h4000_0080);
    wr(18, 32'h4000_0080); chk_levels("R6 module error level 15");
    wr(18, 32'h4000_0000); chk_levels("R9 clear keeps asserted request");
    rd(16, "R9 status follows input");
    set_dev(32'h0000_0080); chk_levels("R6 expansion bit 7 level 1");
    rd(16, "R9 status drops with input");
    set_dev(32'h0);        chk_levels("R1 idle after drop");

    for (int i = 0; i < 600; i++) begin
      int op, c;
      logic [31:0] d;
      op = int'($urandom % 7);
      c = int'($urandom % NCPU);
      d = $urandom & $urandom & $urandom;
      case (op)
        0: wr(4*c + 2, d);
        1: wr(4*c + 1, d | $urandom);
        2: wr(18, d | (($urandom % 2 == 0) ? 32'h8000_0000 : 32'h0));
        3: wr(19, d & ~32'h8000_0000);
        4: wr(20, $urandom % 16);
        5: set_dev($urandom & $urandom);
        default: wr(19, 32'h8000_0000);
      endcase
      chk_levels("R1 random levels");
      if (i % 4 == 0) rd(int'($urandom % 24), "R11 random read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule